// File: doc/BRIEF.md
# Digital Quadrature Modulator Datapath

This block takes paired I and Q samples and mixes them onto a digital carrier for two converter channels. Channel A carries `I*cos - Q*sin` and channel B carries `I*sin + Q*cos`. The carrier runs at either one half or one quarter of the modulator sample rate. Every carrier coefficient is therefore +1, 0 or -1, and the mixing needs only negation, a zero and one add per channel, with no multiplier. Bypass mode passes I to channel A and Q to channel B unchanged. A configuration bit can treat incoming samples as offset binary. When it is set, each sample is converted to two's complement before mixing. A second bit reverses the sign of the sine term, which mirrors the spectrum around the carrier.

A small state machine holds the carrier phase in one of four states, PH0 to PH3. It has three transitions. *Advance* moves to the next phase on each valid sample: PH0 to PH1 to PH2 to PH3 and back to PH0 for the quarter-rate carrier, and PH0 to PH1 and back to PH0 for the half-rate carrier. *Hold* keeps the phase on cycles with no valid sample. *Clear* forces PH0 when the carrier selection or the sine sign differs from its value in the previous cycle. A sample that arrives in that same cycle is mixed with the PH0 coefficients. Bypass always stays in PH0.

The block also decodes the interpolation factor into a one-hot sample-rate multiplier for the modulator. The multiplier is 1 for 1x interpolation, 2 for 2x, and 4 for both 4x and 8x. Upstream logic presents one sample per `in_valid` at that rate. Each sample appears on the outputs with `out_valid` one clock later.

Top module: `qmod_datapath`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid` is 0 and `out_a`, `out_b` are 0.
- R2: With `cfg_offset_bin` = 1, the MSB of each input sample is inverted before mixing. In bypass this maps input 0x800 to output 0, input 0x000 to -2048 (0x800) and input 0xFFF to 2047.
- R3: When `cfg_carrier` = 00 (bypass; 11 behaves the same), a valid sample gives `out_a` = I and `out_b` = Q. `out_valid` equals `in_valid` of the previous cycle.
- R4: When `cfg_carrier` = 10 (quarter rate), successive valid samples use (cos, sin) = (1,0), (0,1), (-1,0), (0,-1), and the sequence then repeats.
- R5: When `cfg_carrier` = 01 (half rate), successive valid samples use (cos, sin) = (1,1), then (-1,-1), and the pair then repeats.
- R6: `cfg_sin_neg` = 1 negates the sine coefficient in both carrier modes.
- R7: Results are saturated to the range -2048..2047. This includes the negation of -2048, which gives 2047.
- R8: The phase advances only on cycles where `in_valid` = 1. Idle cycles leave it unchanged.
- R9: A change of `cfg_carrier` or `cfg_sin_neg` returns the phase to PH0, and a sample in that cycle uses PH0.
- R10: `rate_sel` is one-hot. It is 001 for `cfg_interp` = 00, 010 for 01, and 100 for both 10 and 11.
- R11: On cycles without a valid sample, `out_a` and `out_b` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_carrier | input | 2 | 00 bypass, 01 half-rate carrier, 10 quarter-rate carrier, 11 bypass |
| cfg_sin_neg | input | 1 | Negate the sine coefficient |
| cfg_offset_bin | input | 1 | Inputs are offset binary |
| cfg_interp | input | 2 | Interpolation factor: 00 1x, 01 2x, 10 4x, 11 8x |
| in_valid | input | 1 | Input sample present |
| in_i | input | 12 | In-phase sample |
| in_q | input | 12 | Quadrature sample |
| out_valid | output | 1 | Output sample present |
| out_a | output | 12 | Channel A result, two's complement |
| out_b | output | 12 | Channel B result, two's complement |
| rate_sel | output | 3 | One-hot modulator rate multiplier (x1, x2, x4) |

## Verification
A mixed result and its `out_valid` are due exactly one rising edge after the sample is presented. A phase clear takes effect in the same cycle as the configuration change. `rate_sel` is combinational and settles within the cycle in which `cfg_interp` changes. The bench drives inputs on falling edges and samples on the next falling edge, so exactly one rising edge lies between stimulus and check. It keeps its own phase counter and clears it whenever it changes the carrier selection or sign. It reads `rate_sel` a fraction of a cycle after changing `cfg_interp`.

// File: rtl/qmod_pkg.sv
package qmod_pkg;

    typedef enum logic [1:0] {
        CAR_BYPASS  = 2'b00,
        CAR_HALF    = 2'b01,
        CAR_QUARTER = 2'b10,
        CAR_RSVD    = 2'b11
    } carrier_e;

    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2,
        PH3 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        K_ZERO = 2'd0,
        K_POS  = 2'd1,
        K_NEG  = 2'd2
    } coef_e;

    function automatic coef_e coef_flip(coef_e k);
        case (k)
            K_POS:   return K_NEG;
            K_NEG:   return K_POS;
            default: return K_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/qmod_rate_dec.sv
module qmod_rate_dec #(
    parameter int IW = 2,
    parameter int RW = 3
) (
    input  logic [IW-1:0] interp,
    output logic [RW-1:0] rate_sel
);
    localparam int TOP_IDX = RW - 1;

    logic [IW-1:0] idx;

    always_comb begin
        if (int'(interp) > TOP_IDX) begin
            idx = IW'(TOP_IDX);
        end else begin
            idx = interp;
        end
        rate_sel = RW'(1) << idx;
    end

endmodule

// File: rtl/qmod_phase_fsm.sv
module qmod_phase_fsm
    import qmod_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  carrier_e mode,
    input  logic     sin_neg,
    input  logic     adv,
    output coef_e    k_cos,
    output coef_e    k_sin
);
    carrier_e mode_q;
    logic     neg_q;
    phase_e   st_q;
    phase_e   st_eff;
    phase_e   st_nxt;
    logic     cfg_chg;
    coef_e    raw_sin;

    assign cfg_chg = (mode != mode_q) || (sin_neg != neg_q);
    assign st_eff  = cfg_chg ? PH0 : st_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PH0;
            mode_q <= CAR_BYPASS;
            neg_q  <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            mode_q <= mode;
            neg_q  <= sin_neg;
        end
    end

    // next state: advance, hold or clear
    always_comb begin
        st_nxt = st_eff;
        if (adv) begin
            unique case (st_eff)
                PH0: st_nxt = (mode == CAR_HALF || mode == CAR_QUARTER) ? PH1 : PH0;
                PH1: st_nxt = (mode == CAR_QUARTER) ? PH2 : PH0;
                PH2: st_nxt = (mode == CAR_QUARTER) ? PH3 : PH0;
                PH3: st_nxt = PH0;
            endcase
        end
    end

    // outputs: carrier coefficients of the effective phase
    always_comb begin
        k_cos   = K_POS;
        raw_sin = K_ZERO;
        if (mode == CAR_QUARTER) begin
            unique case (st_eff)
                PH0: begin k_cos = K_POS;  raw_sin = K_ZERO; end
                PH1: begin k_cos = K_ZERO; raw_sin = K_POS;  end
                PH2: begin k_cos = K_NEG;  raw_sin = K_ZERO; end
                PH3: begin k_cos = K_ZERO; raw_sin = K_NEG;  end
            endcase
        end else if (mode == CAR_HALF) begin
            k_cos   = (st_eff == PH0) ? K_POS : K_NEG;
            raw_sin = k_cos;
        end
        k_sin = sin_neg ? coef_flip(raw_sin) : raw_sin;
    end

    // R8
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cfg_chg) |=> (st_q == $past(st_q)));

    // R9
    phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chg && !adv) |=> (st_q == PH0));

    // R5
    half_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAR_HALF && adv && !cfg_chg && st_q == PH0) |=> (st_q == PH1));

    // R4
    quarter_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAR_QUARTER && adv && !cfg_chg && st_q == PH3) |=> (st_q == PH0));

endmodule

// File: rtl/qmod_mixer.sv
module qmod_mixer
    import qmod_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] smp_i,
    input  logic [DW-1:0] smp_q,
    input  coef_e         k_cos,
    input  coef_e         k_sin,
    output logic          out_valid,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b
);
    localparam int EW = DW + 1;
    localparam int SW = DW + 2;

    function automatic logic [EW-1:0] scale(logic [DW-1:0] x, coef_e k);
        logic [EW-1:0] ext;
        ext = {x[DW-1], x};
        case (k)
            K_POS:   return ext;
            K_NEG:   return -ext;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] clamp(logic [SW-1:0] v);
        if ((&v[SW-1:DW-1]) || !(|v[SW-1:DW-1])) begin
            return v[DW-1:0];
        end else if (v[SW-1]) begin
            return {1'b1, {(DW-1){1'b0}}};
        end else begin
            return {1'b0, {(DW-1){1'b1}}};
        end
    endfunction

    logic [EW-1:0] i_c, q_s, i_s, q_c;
    logic [SW-1:0] sum_a, sum_b;

    always_comb begin
        i_c   = scale(smp_i, k_cos);
        q_s   = scale(smp_q, k_sin);
        i_s   = scale(smp_i, k_sin);
        q_c   = scale(smp_q, k_cos);
        sum_a = {i_c[EW-1], i_c} - {q_s[EW-1], q_s};
        sum_b = {i_s[EW-1], i_s} + {q_c[EW-1], q_c};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_a     <= '0;
            out_b     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_a <= clamp(sum_a);
                out_b <= clamp(sum_b);
            end
        end
    end

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_a) && $stable(out_b)));

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && k_cos == K_POS && k_sin == K_ZERO)
        |=> (out_a == $past(smp_i) && out_b == $past(smp_q)));

endmodule

// File: rtl/qmod_datapath.sv
module qmod_datapath
    import qmod_pkg::*;
#(
    parameter int DW = 12,
    parameter int IW = 2,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_carrier,
    input  logic          cfg_sin_neg,
    input  logic          cfg_offset_bin,
    input  logic [IW-1:0] cfg_interp,
    input  logic          in_valid,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    output logic          out_valid,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b,
    output logic [RW-1:0] rate_sel
);
    logic [DW-1:0] tc_i, tc_q;
    coef_e         k_cos, k_sin;
    carrier_e      mode;

    assign mode = carrier_e'(cfg_carrier);
    assign tc_i = {in_i[DW-1] ^ cfg_offset_bin, in_i[DW-2:0]};
    assign tc_q = {in_q[DW-1] ^ cfg_offset_bin, in_q[DW-2:0]};

    qmod_rate_dec #(.IW(IW), .RW(RW)) rate_i (
        .interp   (cfg_interp),
        .rate_sel (rate_sel)
    );

    qmod_phase_fsm phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .sin_neg (cfg_sin_neg),
        .adv     (in_valid),
        .k_cos   (k_cos),
        .k_sin   (k_sin)
    );

    qmod_mixer #(.DW(DW)) mix_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .smp_i     (tc_i),
        .smp_q     (tc_q),
        .k_cos     (k_cos),
        .k_sin     (k_sin),
        .out_valid (out_valid),
        .out_a     (out_a),
        .out_b     (out_b)
    );

    // R10
    rate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rate_sel));

    // R10
    rate_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_interp) >= RW - 1) |-> rate_sel[RW-1]);

endmodule

// File: tb/qmod_datapath_tb_top.sv
`timescale 1ns/1ps
module qmod_datapath_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_carrier = 2'b00;
    logic        cfg_sin_neg = 1'b0;
    logic        cfg_offset_bin = 1'b0;
    logic [1:0]  cfg_interp = 2'b00;
    logic        in_valid = 1'b0;
    logic [11:0] in_i = '0;
    logic [11:0] in_q = '0;
    logic        out_valid;
    logic [11:0] out_a, out_b;
    logic [2:0]  rate_sel;

    int n_chk = 0;
    int n_err = 0;
    int ph = 0;
    logic [1:0] last_car = 2'b00;
    logic       last_neg = 1'b0;
    int exp_a = 0;
    int exp_b = 0;

    always #2.5 clk = ~clk;

    qmod_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_carrier(cfg_carrier), .cfg_sin_neg(cfg_sin_neg),
        .cfg_offset_bin(cfg_offset_bin), .cfg_interp(cfg_interp), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
        .rate_sel(rate_sel)
    );

    function automatic void check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endfunction

    function automatic int sat(int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int to_int(logic [11:0] x, bit offs);
        if (offs) return int'(x) - 2048;
        return int'($signed(x));
    endfunction

    // one cycle: drive at a falling edge, check at the next falling edge
    task automatic step(bit v, logic [11:0] i, logic [11:0] q, string req);
        int c, s, iv, qv;
        if (cfg_carrier != last_car || cfg_sin_neg != last_neg) ph = 0; // R9
        last_car = cfg_carrier;
        last_neg = cfg_sin_neg;
        in_valid = v;
        in_i = i;
        in_q = q;
        if (v) begin
            c = 1; s = 0;
            if (cfg_carrier == 2'b10) begin
                case (ph)
                    0: begin c = 1;  s = 0;  end
                    1: begin c = 0;  s = 1;  end
                    2: begin c = -1; s = 0;  end
                    default: begin c = 0; s = -1; end
                endcase
                ph = (ph + 1) % 4;
            end else if (cfg_carrier == 2'b01) begin
                c = (ph == 0) ? 1 : -1;
                s = c;
                ph = (ph + 1) % 2;
            end
            if (cfg_sin_neg) s = -s;
            iv = to_int(i, cfg_offset_bin);
            qv = to_int(q, cfg_offset_bin);
            exp_a = sat(iv * c - qv * s);
            exp_b = sat(iv * s + qv * c);
        end
        @(negedge clk);
        check(out_valid == v, {req, " valid"}, int'(out_valid), int'(v));
        check(int'($signed(out_a)) == exp_a, {req, " out_a"}, int'($signed(out_a)), exp_a);
        check(int'($signed(out_b)) == exp_b, {req, " out_b"}, int'($signed(out_b)), exp_b);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_a == 12'd0, "R1 out_a", int'(out_a), 0);
        check(out_b == 12'd0, "R1 out_b", int'(out_b), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_a == 12'd0, "R1 after release", int'(out_a), 0);
    endtask

    task automatic t_rate();
        logic [2:0] want [4] = '{3'b001, 3'b010, 3'b100, 3'b100};
        for (int k = 0; k < 4; k++) begin
            cfg_interp = 2'(k);
            #0.5;
            check(rate_sel == want[k], "R10 rate_sel", int'(rate_sel), int'(want[k]));
        end
    endtask

    task automatic t_bypass();
        cfg_carrier = 2'b00;
        step(1, 12'd100, 12'hED4, "R3 bypass");
        step(1, 12'h7FF, 12'h800, "R3 bypass extremes");
        step(0, 12'h123, 12'h456, "R11 idle hold");
        step(0, 12'h000, 12'hFFF, "R11 idle hold");
        cfg_carrier = 2'b11;
        step(1, 12'h3A5, 12'hC01, "R3 reserved code");
    endtask

    task automatic t_offset();
        cfg_carrier = 2'b00;
        cfg_offset_bin = 1'b1;
        step(1, 12'h800, 12'h000, "R2 offset mid/min");
        check(out_a == 12'h000 && out_b == 12'h800, "R2 codes", int'(out_b), 2048);
        step(1, 12'hFFF, 12'h801, "R2 offset max");
        cfg_offset_bin = 1'b0;
    endtask

    task automatic t_quarter();
        cfg_carrier = 2'b10;
        cfg_sin_neg = 1'b0;
        for (int k = 0; k < 8; k++) step(1, 12'd100, 12'hED4, "R4 quarter");
        step(1, 12'd517, 12'd33, "R4 quarter p0");
        step(1, 12'hF00, 12'd700, "R4 quarter p1");
    endtask

    task automatic t_half();
        cfg_carrier = 2'b01;
        for (int k = 0; k < 4; k++) step(1, 12'd300, 12'd50, "R5 half");
        cfg_sin_neg = 1'b1;
        for (int k = 0; k < 4; k++) step(1, 12'd300, 12'd50, "R6 half neg");
        cfg_sin_neg = 1'b0;
    endtask

    task automatic t_sign();
        cfg_carrier = 2'b10;
        cfg_sin_neg = 1'b1;
        for (int k = 0; k < 4; k++) step(1, 12'd100, 12'hED4, "R6 quarter neg");
        cfg_sin_neg = 1'b0;
    endtask

    task automatic t_sat();
        cfg_carrier = 2'b01;
        step(1, 12'h7FF, 12'h800, "R7 half pos sat");
        step(1, 12'h7FF, 12'h800, "R7 half neg sat");
        cfg_carrier = 2'b10;
        step(1, 12'd1, 12'd1, "R7 quarter p0");
        step(1, 12'd1, 12'd1, "R7 quarter p1");
        step(1, 12'h800, 12'h800, "R7 negate min");
        check(out_a == 12'h7FF, "R7 -(-2048)", int'(out_a), 2047);
    endtask

    task automatic t_gap();
        cfg_carrier = 2'b01;
        step(0, 12'd0, 12'd0, "R8 setup");
        cfg_carrier = 2'b10;
        step(1, 12'd200, 12'd10, "R8 p0");
        step(0, 12'd9, 12'd9, "R8 gap");
        step(0, 12'd9, 12'd9, "R8 gap");
        step(0, 12'd9, 12'd9, "R8 gap");
        step(1, 12'd200, 12'd10, "R8 p1 after gap");
        check(int'($signed(out_a)) == -10, "R8 phase kept", int'($signed(out_a)), -10);
    endtask

    task automatic t_modechg();
        cfg_carrier = 2'b10;
        step(1, 12'd40, 12'd7, "R9 q");
        step(1, 12'd40, 12'd7, "R9 q");
        cfg_sin_neg = 1'b1;
        step(1, 12'd40, 12'd7, "R9 clear on sign");
        check(int'($signed(out_a)) == 40, "R9 p0 after sign", int'($signed(out_a)), 40);
        step(1, 12'd40, 12'd7, "R9 q neg");
        cfg_carrier = 2'b01;
        cfg_sin_neg = 1'b0;
        step(0, 12'd0, 12'd0, "R9 clear idle");
        cfg_carrier = 2'b10;
        step(1, 12'd40, 12'd7, "R9 clear on mode");
        check(int'($signed(out_b)) == 7, "R9 p0 after mode", int'($signed(out_b)), 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_rate();
        t_bypass();
        t_offset();
        t_quarter();
        t_half();
        t_sign();
        t_sat();
        t_gap();
        t_modechg();
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    end

endmodule